// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Sequencer

This block produces the sixteen gate-drive lines of a phase-shifted full-bridge DC/DC converter that has auxiliary resonant commutation switches and synchronous rectification. There are eight channels, each with a high drive line and a low drive line: the two main bridge legs, four auxiliary commutation switches (one per leg transition) and two rectifiers. All edges are derived from a single free-running period counter, so the whole pattern repeats every `PERIOD` clock cycles.

The output voltage is controlled at run time through one input, the phase shift between the right leg and the left leg. Dead times and per-edge driver-delay compensations are fixed integer cycle counts set by parameters. The right-leg group is timed from its earliest event, the turn-off of the positive-side rectifier. The left-leg group is held back by a virtual lead of the same size, so that a phase input of zero aligns the two legs.

When the enable input is low, or while reset is held, every gate line is driven low. Low on both lines of a pair is the safe state.

Top module: `psfb_gate_seq`

## Requirements
- R1: An internal count runs from 0 to `PERIOD-1` and wraps while `en` is high. The gate outputs are registered, so the sample taken after the n-th clock edge with `en` high shows the pattern for count n-1.
- R2: Channel index order is 0 left main, 1 right main, 2 left aux for the rising transition, 3 left aux for the falling transition, 4 right aux rising, 5 right aux falling, 6 positive rectifier, 7 negative rectifier. `gate_hi[i]` and `gate_lo[i]` are never high together. When both windows of a pair request on, both lines are driven low.
- R3: With L=`SR_LEAD` and H=`PERIOD/2`, the left main high window is [L+`DT_FB`, L+H) and its low window is [L+H+`DT_FB`, L+`PERIOD`).
- R4: The right main uses the same windows as R3, with anchor phase+L in place of L. The rectifier off edge that opens the right group sits at `phase`.
- R5: An aux channel with anchor a has high window [a, a+`AUX_ON`) and low window [a+`AUX_ON`+`DT_AUX`, a+`PERIOD`-`DT_AUX`). The anchors are L and L+H for channels 2 and 3, and phase+L and phase+L+H for channels 4 and 5.
- R6: The positive rectifier has high window [L+`DT_SR`, phase) and low window [phase+`DT_SR`, L+`PERIOD`). The negative rectifier uses the same windows shifted by H.
- R7: Each of the four edges of a channel is moved earlier by its own 8-bit field. Channel i's field sits at bits [8i+7:8i] of `COMP_HI_ON`, `COMP_HI_OFF`, `COMP_LO_ON` or `COMP_LO_OFF`. All edges are taken modulo `PERIOD`. A window whose on and off edges are equal is empty.
- R8: The applied phase is `phase_in` clamped to the range [`SR_LEAD`+`DT_SR`+1, `PERIOD/2`].
- R9: While `en` is high, a new phase is taken only on the edge where the count wraps. It is therefore first used at count 0 of the next period.
- R10: Reset clears the count and all outputs immediately and sets the applied phase to its lower clamp. While `en` is low, the count holds at 0, the phase follows `phase_in`, and all outputs are low from the next edge on. When `en` is raised again, the pattern restarts at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces all gates off |
| phase_in | input | $clog2(PERIOD) | Requested right-to-left leg phase shift in cycles |
| gate_hi | output | 8 | High drive line of each channel |
| gate_lo | output | 8 | Low drive line of each channel |

## Verification
Every phase value from zero up to past half a period is applied for one full period. The in-range values check that the right-group windows slide with the phase while the left group stays fixed. The values below and above the range confirm that the clamp applies, and not wrap-around. Unequal compensation fields per channel and per edge would expose a field decoded at the wrong bit position or applied to the wrong edge; some of them exceed a dead time on purpose, which forces the interlock to blank both lines of a pair. Phase changes are made in the middle of a period and one count before the wrap, to place the hand-over exactly. Enable drops and an asynchronous reset in the middle of a period confirm the restart at count 0 and the phase restored by reset.

// File: rtl/pfbs_pkg.sv
package pfbs_pkg;

    localparam int NCH = 8;

    localparam int CH_MAIN_L = 0;
    localparam int CH_MAIN_R = 1;
    localparam int CH_AUX_LR = 2;
    localparam int CH_AUX_LF = 3;
    localparam int CH_AUX_RR = 4;
    localparam int CH_AUX_RF = 5;
    localparam int CH_SR_P   = 6;
    localparam int CH_SR_N   = 7;

    typedef enum logic [1:0] {
        K_MAIN,
        K_AUX,
        K_SR
    } chan_kind_e;

    // Fold a value in [-p, 3p) into [0, p).
    function automatic int wrap_period(int x, int p);
        int r;
        r = x;
        if (r < 0)  r = r + p;
        if (r >= p) r = r - p;
        if (r >= p) r = r - p;
        return r;
    endfunction

endpackage

// File: rtl/pfbs_timebase.sv
module pfbs_timebase #(
    parameter int PERIOD = 1000,
    parameter int CNT_W  = 10,
    parameter int PH_MIN = 1,
    parameter int PH_MAX = 500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] phase_in,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] phase
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ph;
    } tb_state_t;

    tb_state_t        st_d, st_q;
    logic [CNT_W-1:0] ph_clamped;

    always_comb begin
        ph_clamped = phase_in;
        if (phase_in < CNT_W'(PH_MIN)) begin
            ph_clamped = CNT_W'(PH_MIN);
        end else if (phase_in > CNT_W'(PH_MAX)) begin
            ph_clamped = CNT_W'(PH_MAX);
        end

        st_d = st_q;
        if (!en) begin
            st_d.cnt = '0;
            st_d.ph  = ph_clamped;
        end else if (st_q.cnt == CNT_W'(PERIOD - 1)) begin
            st_d.cnt = '0;
            st_d.ph  = ph_clamped;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.ph  <= CNT_W'(PH_MIN);
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign phase = st_q.ph;

endmodule

// File: rtl/pfbs_edge_plan.sv
module pfbs_edge_plan
    import pfbs_pkg::*;
#(
    parameter int PERIOD  = 1000,
    parameter int CNT_W   = 10,
    parameter int SR_LEAD = 20,
    parameter int DT_FB   = 30,
    parameter int DT_AUX  = 10,
    parameter int DT_SR   = 15,
    parameter int AUX_ON  = 60,
    parameter int COMP_W  = 8,
    parameter logic [NCH*COMP_W-1:0] COMP_HI_ON  = '0,
    parameter logic [NCH*COMP_W-1:0] COMP_HI_OFF = '0,
    parameter logic [NCH*COMP_W-1:0] COMP_LO_ON  = '0,
    parameter logic [NCH*COMP_W-1:0] COMP_LO_OFF = '0
) (
    input  logic [CNT_W-1:0]          phase,
    output logic [NCH-1:0][CNT_W-1:0] hi_on,
    output logic [NCH-1:0][CNT_W-1:0] hi_off,
    output logic [NCH-1:0][CNT_W-1:0] lo_on,
    output logic [NCH-1:0][CNT_W-1:0] lo_off
);

    localparam int HALF = PERIOD / 2;

    always_comb begin
        int         ph;
        int         anc;
        int         stop;
        int         e_hon;
        int         e_hoff;
        int         e_lon;
        int         e_loff;
        chan_kind_e kind;

        ph = int'(phase);
        for (int ch = 0; ch < NCH; ch++) begin
            kind = K_MAIN;
            anc  = SR_LEAD;
            stop = ph;
            case (ch)
                CH_MAIN_L: begin kind = K_MAIN; anc = SR_LEAD;             end
                CH_MAIN_R: begin kind = K_MAIN; anc = ph + SR_LEAD;        end
                CH_AUX_LR: begin kind = K_AUX;  anc = SR_LEAD;             end
                CH_AUX_LF: begin kind = K_AUX;  anc = SR_LEAD + HALF;      end
                CH_AUX_RR: begin kind = K_AUX;  anc = ph + SR_LEAD;        end
                CH_AUX_RF: begin kind = K_AUX;  anc = ph + SR_LEAD + HALF; end
                CH_SR_P:   begin kind = K_SR;   anc = SR_LEAD;        stop = ph;        end
                CH_SR_N:   begin kind = K_SR;   anc = SR_LEAD + HALF; stop = ph + HALF; end
                default:   ;
            endcase

            case (kind)
                K_MAIN: begin
                    e_hon  = anc + DT_FB;
                    e_hoff = anc + HALF;
                    e_lon  = anc + HALF + DT_FB;
                    e_loff = anc + PERIOD;
                end
                K_AUX: begin
                    e_hon  = anc;
                    e_hoff = anc + AUX_ON;
                    e_lon  = anc + AUX_ON + DT_AUX;
                    e_loff = anc + PERIOD - DT_AUX;
                end
                default: begin
                    e_hon  = anc + DT_SR;
                    e_hoff = stop;
                    e_lon  = stop + DT_SR;
                    e_loff = anc + PERIOD;
                end
            endcase

            hi_on[ch]  = CNT_W'(wrap_period(e_hon  - int'(COMP_HI_ON [ch*COMP_W +: COMP_W]), PERIOD));
            hi_off[ch] = CNT_W'(wrap_period(e_hoff - int'(COMP_HI_OFF[ch*COMP_W +: COMP_W]), PERIOD));
            lo_on[ch]  = CNT_W'(wrap_period(e_lon  - int'(COMP_LO_ON [ch*COMP_W +: COMP_W]), PERIOD));
            lo_off[ch] = CNT_W'(wrap_period(e_loff - int'(COMP_LO_OFF[ch*COMP_W +: COMP_W]), PERIOD));
        end
    end

endmodule

// File: rtl/pfbs_pair_gate.sv
module pfbs_pair_gate #(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] hi_on,
    input  logic [CNT_W-1:0] hi_off,
    input  logic [CNT_W-1:0] lo_on,
    input  logic [CNT_W-1:0] lo_off,
    output logic             hi,
    output logic             lo
);

    // Cyclic window [r, f): empty when r == f, wraps when r > f.
    function automatic logic in_window(logic [CNT_W-1:0] c,
                                       logic [CNT_W-1:0] r,
                                       logic [CNT_W-1:0] f);
        if (r == f) return 1'b0;
        if (r < f)  return (c >= r) && (c < f);
        return (c >= r) || (c < f);
    endfunction

    logic hi_want;
    logic lo_want;

    assign hi_want = in_window(cnt, hi_on, hi_off);
    assign lo_want = in_window(cnt, lo_on, lo_off);

    // Interlock: a conflicting request drops both lines.
    assign hi = hi_want & ~lo_want;
    assign lo = lo_want & ~hi_want;

endmodule

// File: rtl/psfb_gate_seq.sv
module psfb_gate_seq
    import pfbs_pkg::*;
#(
    parameter int PERIOD  = 1000,
    parameter int SR_LEAD = 20,
    parameter int DT_FB   = 30,
    parameter int DT_AUX  = 10,
    parameter int DT_SR   = 15,
    parameter int AUX_ON  = 60,
    parameter int COMP_W  = 8,
    parameter logic [NCH*COMP_W-1:0] COMP_HI_ON  = {NCH{COMP_W'(6)}},
    parameter logic [NCH*COMP_W-1:0] COMP_HI_OFF = {NCH{COMP_W'(4)}},
    parameter logic [NCH*COMP_W-1:0] COMP_LO_ON  = {NCH{COMP_W'(6)}},
    parameter logic [NCH*COMP_W-1:0] COMP_LO_OFF = {NCH{COMP_W'(4)}},
    localparam int CNT_W = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] phase_in,
    output logic [NCH-1:0]   gate_hi,
    output logic [NCH-1:0]   gate_lo
);

    localparam int HALF   = PERIOD / 2;
    localparam int PH_MIN = SR_LEAD + DT_SR + 1;
    localparam int PH_MAX = HALF;

    typedef struct packed {
        logic [NCH-1:0] hi;
        logic [NCH-1:0] lo;
    } drv_t;

    logic [CNT_W-1:0]          tb_cnt;
    logic [CNT_W-1:0]          tb_ph;
    logic [NCH-1:0][CNT_W-1:0] e_hi_on, e_hi_off, e_lo_on, e_lo_off;
    logic [NCH-1:0]            hi_req, lo_req;
    drv_t                      drv_d, drv_q;

    pfbs_timebase #(
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W),
        .PH_MIN (PH_MIN),
        .PH_MAX (PH_MAX)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .phase_in (phase_in),
        .cnt      (tb_cnt),
        .phase    (tb_ph)
    );

    pfbs_edge_plan #(
        .PERIOD      (PERIOD),
        .CNT_W       (CNT_W),
        .SR_LEAD     (SR_LEAD),
        .DT_FB       (DT_FB),
        .DT_AUX      (DT_AUX),
        .DT_SR       (DT_SR),
        .AUX_ON      (AUX_ON),
        .COMP_W      (COMP_W),
        .COMP_HI_ON  (COMP_HI_ON),
        .COMP_HI_OFF (COMP_HI_OFF),
        .COMP_LO_ON  (COMP_LO_ON),
        .COMP_LO_OFF (COMP_LO_OFF)
    ) u_plan (
        .phase  (tb_ph),
        .hi_on  (e_hi_on),
        .hi_off (e_hi_off),
        .lo_on  (e_lo_on),
        .lo_off (e_lo_off)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_pair
        pfbs_pair_gate #(
            .CNT_W (CNT_W)
        ) u_pair (
            .cnt    (tb_cnt),
            .hi_on  (e_hi_on[g]),
            .hi_off (e_hi_off[g]),
            .lo_on  (e_lo_on[g]),
            .lo_off (e_lo_off[g]),
            .hi     (hi_req[g]),
            .lo     (lo_req[g])
        );
    end

    always_comb begin
        drv_d.hi = en ? hi_req : '0;
        drv_d.lo = en ? lo_req : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign gate_hi = drv_q.hi;
    assign gate_lo = drv_q.lo;

endmodule

module psfb_gate_seq_chk
    import pfbs_pkg::*;
#(
    parameter int PERIOD = 1000,
    parameter int CNT_W  = 10,
    parameter int PH_MIN = 1,
    parameter int PH_MAX = 500
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] ph,
    input logic [NCH-1:0]   gate_hi,
    input logic [NCH-1:0]   gate_lo
);

    // R2: the two lines of a pair are never high together
    a_r2_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);

    // R10: an enable seen low leaves every gate off one edge later
    a_r10_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (gate_hi == '0) && (gate_lo == '0));

    // R1: the count stays inside the period
    a_r1_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(PERIOD - 1));

    // R1: the count steps by one and wraps at the period end
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en) |->
            cnt == (($past(cnt) == CNT_W'(PERIOD - 1)) ? '0 : CNT_W'($past(cnt) + 1'b1)));

    // R9: the applied phase only moves when the period restarts
    a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en) && (cnt != '0) |-> $stable(ph));

    // R8: the applied phase stays inside its clamp
    a_r8_phase_window: assert property (@(posedge clk) disable iff (!rst_n)
        (ph >= CNT_W'(PH_MIN)) && (ph <= CNT_W'(PH_MAX)));

endmodule

bind psfb_gate_seq psfb_gate_seq_chk #(
    .PERIOD (PERIOD),
    .CNT_W  (CNT_W),
    .PH_MIN (PH_MIN),
    .PH_MAX (PH_MAX)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .cnt     (tb_cnt),
    .ph      (tb_ph),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo)
);

// File: tb/psfb_gate_seq_bench.sv
`timescale 1ns/1ps
module psfb_gate_seq_bench;

    localparam int P     = 40;
    localparam int H     = P / 2;
    localparam int SRL   = 2;
    localparam int DTF   = 3;
    localparam int DTA   = 1;
    localparam int DTS   = 2;
    localparam int AON   = 4;
    localparam int PHMIN = SRL + DTS + 1;
    localparam int PHMAX = H;

    // R7: channel i's compensation in bits [8i+7:8i]
    function automatic logic [63:0] mk_comp(int kind);
        logic [63:0] r;
        int v;
        r = '0;
        for (int ch = 0; ch < 8; ch++) begin
            case (kind)
                0:       v = ch % 3;
                1:       v = (ch + 1) % 3;
                2:       v = (2 * ch) % 5;
                default: v = (3 * ch) % 4;
            endcase
            r[ch*8 +: 8] = 8'(v);
        end
        return r;
    endfunction

    localparam logic [63:0] B_HON  = mk_comp(0);
    localparam logic [63:0] B_HOFF = mk_comp(1);
    localparam logic [63:0] B_LON  = mk_comp(2);
    localparam logic [63:0] B_LOFF = mk_comp(3);

    logic       clk;
    logic       rst_n;
    logic       en;
    logic [5:0] phase_in;
    logic [7:0] gate_hi;
    logic [7:0] gate_lo;

    int vectors = 0;
    int misses  = 0;

    psfb_gate_seq #(
        .PERIOD      (P),
        .SR_LEAD     (SRL),
        .DT_FB       (DTF),
        .DT_AUX      (DTA),
        .DT_SR       (DTS),
        .AUX_ON      (AON),
        .COMP_W      (8),
        .COMP_HI_ON  (B_HON),
        .COMP_HI_OFF (B_HOFF),
        .COMP_LO_ON  (B_LON),
        .COMP_LO_OFF (B_LOFF)
    ) u_psfb_gate_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .phase_in (phase_in),
        .gate_hi  (gate_hi),
        .gate_lo  (gate_lo)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic int md(int x);
        return ((x % P) + P) % P;
    endfunction

    function automatic int cget(logic [63:0] v, int ch);
        return int'(v[ch*8 +: 8]);
    endfunction

    function automatic bit in_w(int c, int r, int f);
        if (r == f) return 1'b0;
        if (r < f)  return (c >= r) && (c < f);
        return (c >= r) || (c < f);
    endfunction

    function automatic int clampb(int ph);
        if (ph < PHMIN) return PHMIN;
        if (ph > PHMAX) return PHMAX;
        return ph;
    endfunction

    // Expected {hi, lo} of one channel at count c with applied phase ph
    function automatic logic [1:0] exp_pair(int ch, int c, int ph);
        int a, e, hon, hoff, lon, loff;
        bit h, l;
        if (ch < 2) begin
            a = SRL + ((ch == 1) ? ph : 0);
            hon = a + DTF; hoff = a + H; lon = a + H + DTF; loff = a;
        end else if (ch < 6) begin
            a = SRL + ((ch == 4 || ch == 5) ? ph : 0) + ((ch == 3 || ch == 5) ? H : 0);
            hon = a; hoff = a + AON; lon = a + AON + DTA; loff = a - DTA;
        end else begin
            a = SRL + ((ch == 7) ? H : 0);
            e = ph + ((ch == 7) ? H : 0);
            hon = a + DTS; hoff = e; lon = e + DTS; loff = a;
        end
        h = in_w(c, md(hon - cget(B_HON, ch)), md(hoff - cget(B_HOFF, ch)));
        l = in_w(c, md(lon - cget(B_LON, ch)), md(loff - cget(B_LOFF, ch)));
        return {h & ~l, l & ~h};
    endfunction

    function automatic string chan_tag(int ch);
        if (ch < 2) return "R3 R4";
        if (ch < 6) return "R5";
        return "R6";
    endfunction

    task automatic check_vec(string ctx, int c, int ph);
        logic [7:0] eh, el;
        logic [1:0] p;
        int bad;
        bad = -1;
        for (int ch = 0; ch < 8; ch++) begin
            p = exp_pair(ch, c, ph);
            eh[ch] = p[1];
            el[ch] = p[0];
            if (bad < 0 && (gate_hi[ch] !== eh[ch] || gate_lo[ch] !== el[ch])) bad = ch;
        end
        vectors++;
        if (bad >= 0) begin
            misses++;
            $display("FAIL %s %s ch%0d count=%0d phase=%0d: hi=%b lo=%b expected hi=%b lo=%b",
                     ctx, chan_tag(bad), bad, c, ph, gate_hi, gate_lo, eh, el);
        end
        vectors++;
        if ((gate_hi & gate_lo) !== 8'h00) begin
            misses++;
            $display("FAIL R2 pair overlap count=%0d: overlap=%b expected 00000000",
                     c, gate_hi & gate_lo);
        end
    endtask

    task automatic check_off(string ctx);
        vectors++;
        if (gate_hi !== 8'h00 || gate_lo !== 8'h00) begin
            misses++;
            $display("FAIL %s: hi=%b lo=%b expected hi=00000000 lo=00000000",
                     ctx, gate_hi, gate_lo);
        end
    endtask

    // Called at the negedge on which en was raised
    task automatic run_en(int nsamp, int init_ph, int chg_at, int new_ph, string ctx);
        int ph_run, ph_seen, c;
        ph_run  = init_ph;
        ph_seen = init_ph;
        for (int n = 0; n < nsamp; n++) begin
            @(negedge clk);
            c = n % P;
            if (c == 0 && n != 0) ph_run = ph_seen;
            check_vec(ctx, c, ph_run);
            if (c == P - 1) ph_seen = clampb(int'(phase_in));
            if (n == chg_at) phase_in = 6'(new_ph);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        misses++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        en       = 1'b0;
        phase_in = '0;
        repeat (3) @(negedge clk);
        check_off("R10 held in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_off("R10 enable low after reset");

        // R1 R7 R8: every phase for a full period, including clamp cases
        for (int ph = 0; ph <= H + 3; ph++) begin
            phase_in = 6'(ph);
            @(negedge clk);
            en = 1'b1;
            if (ph < PHMIN || ph > PHMAX)
                run_en(P, clampb(ph), -1, 0, "R8 clamp sweep");
            else
                run_en(P, ph, -1, 0, "R1 R7 phase sweep");
            en = 1'b0;
            @(negedge clk);
            check_off("R10 disable after period");
        end

        // R9: change in the middle of a period
        phase_in = 6'd10;
        @(negedge clk);
        en = 1'b1;
        run_en(3 * P, 10, 15, 14, "R9 mid-period change");
        en = 1'b0;
        @(negedge clk);
        check_off("R10 disable");

        // R9: change one count before the wrap
        phase_in = 6'd8;
        @(negedge clk);
        en = 1'b1;
        run_en(3 * P, 8, P - 2, 17, "R9 change before wrap");
        en = 1'b0;
        @(negedge clk);
        check_off("R10 disable");

        // R10: enable dropped mid-period restarts at count 0
        phase_in = 6'd12;
        @(negedge clk);
        en = 1'b1;
        run_en(17, 12, -1, 0, "R10 before drop");
        en = 1'b0;
        @(negedge clk);
        check_off("R10 mid-period drop");
        en = 1'b1;
        run_en(P, 12, -1, 0, "R10 restart at zero");

        // R10: asynchronous reset mid-run restores the lower phase clamp
        rst_n = 1'b0;
        #1;
        check_off("R10 async reset immediate");
        @(negedge clk);
        check_off("R10 async reset held");
        rst_n = 1'b1;
        run_en(2 * P, PHMIN, -1, 0, "R10 after reset");
        en = 1'b0;
        @(negedge clk);
        check_off("R10 final disable");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule